// File: doc/BRIEF.md
# Gate Driver Fault and Enable Controller

This block is the digital supervisor next to an isolated gate driver's output stage. A desaturation detector sends it a one-cycle pulse. The controller latches that event as a fault and tells the host by switching on the pull-low path of an open-drain style fault flag. While the fault is latched, the gate is held off and the strong pulldown stays on, whatever the PWM command is.

The host has one shared control line, called the reset/enable line. It does two jobs:

- **Enable.** When the line has been low for long enough (the filter time), the output stage is disabled and the strong pulldown is engaged. At power-on the line is treated as low, so the driver starts disabled. It must be driven high before the gate can follow PWM.
- **Fault clear.** The same line clears a latched fault, with two limits:
  - Low time during a mute window that follows each desaturation event does not count. Only low time after the window has expired counts toward the filter time.
  - The clear does not happen during the low level. It takes effect on the next rising edge of the line.

The line is synchronized through two flops before any filtering or edge detection. All timing is in clock cycles.

Top module: `gdrv_fault_ctrl`

## Requirements
- R1: After power-on reset, with the reset/enable line low, the fault flag pull-low is off (0), `gate_drive` is 0 for any PWM value, and `strong_pd` is 1.
- R2: A desat pulse sampled on a clock edge latches the fault, and `flt_pull_low` reads 1 after that same edge.
- R3: A latched fault never clears by itself, and it is not cleared by low pulses on the reset/enable line that are shorter than FILT_CYC samples.
- R4: Each desat pulse starts a mute window: the counter is loaded with MUTE_CYC and counts down once per cycle. A low sample of the synchronized line counts toward a clear only on an edge where the counter already reads zero. Low time inside the window is not counted.
- R5: The fault clears only when at least FILT_CYC consecutive post-mute low samples are followed by a high sample. The clear is visible three edges after the line is driven high (two synchronizer stages plus the latch). The flag stays set while the line is still low.
- R6: When the synchronized line has been low for FILT_CYC consecutive samples, the driver is disabled and `strong_pd` is 1. A line driven low after edge 0 gives `strong_pd`=1 after edge FILT_CYC+2 and not before. Any high sample restarts the count, so shorter low pulses leave the driver enabled.
- R7: While the fault is latched, `gate_drive` is 0 and `strong_pd` is 1 for any PWM value and any level of the reset/enable line.
- R8: A desat pulse that arrives while a fault is already latched reloads the mute window and discards any post-mute low count gathered so far.
- R9: With no fault and the driver enabled, `gate_drive` equals `pwm_cmd` and `strong_pd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| desat_pulse | input | 1 | Synchronized desaturation detect pulse |
| rsten_in | input | 1 | Asynchronous reset/enable line, low by default |
| pwm_cmd | input | 1 | PWM gate command |
| flt_pull_low | output | 1 | 1 turns on the fault flag's pull-low path |
| gate_drive | output | 1 | Gate-on command to the output stage |
| strong_pd | output | 1 | Strong gate pulldown active |

## Verification
The hardest state to reach from the ports is the boundary where a low pulse straddles the end of the mute window. Only part of that pulse counts, and whether the fault clears depends on exactly how many post-mute samples it had. The bench sweeps the start of the low pulse across the window's last cycles and sweeps the pulse length around the filter time. For each pair it computes from the requirement's edge arithmetic how many samples count, and so whether the rising edge must clear the fault. A second desat pulse fired just before the first window would expire checks that the window restarts.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef struct packed {
        logic fault;
        logic disabled;
    } gdrv_state_t;

    typedef struct packed {
        logic flt_pull_low;
        logic gate_drive;
        logic strong_pd;
    } gdrv_out_t;

    function automatic gdrv_out_t drive_outputs(gdrv_state_t st, logic pwm);
        gdrv_out_t o;
        logic ok;
        ok             = !st.fault && !st.disabled;
        o.flt_pull_low = st.fault;
        o.gate_drive   = ok && pwm;
        o.strong_pd    = !ok;
        return o;
    endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    logic s1, s2, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1   <= async_in;
            s2   <= s1;
            s2_q <= s2;
        end
    end

    assign lvl  = s2;
    assign rise = s2 && !s2_q;

    // R5
    rise_prev_low_chk: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(!lvl));
endmodule

// File: rtl/gdrv_low_filter.sv
module gdrv_low_filter #(
    parameter int FILT_CYC = 8,
    parameter bit RST_FULL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic count_en,
    input  logic clr,
    output logic full
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FULLV = CW'(FILT_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= RST_FULL ? FULLV : '0;
        else if (clr || lvl)
            cnt <= '0;
        else if (count_en && cnt != FULLV)
            cnt <= cnt + 1'b1;
    end

    assign full = (cnt == FULLV);

    // R6
    high_restart_chk: assert property (@(posedge clk) disable iff (rst)
        lvl |=> !full);
    // R6
    no_overcount_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULLV);
endmodule

// File: rtl/gdrv_fault_latch.sv
module gdrv_fault_latch #(
    parameter int MUTE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic desat,
    input  logic arm_full,
    input  logic rise,
    output logic fault,
    output logic mute_done
);
    localparam int MW = $clog2(MUTE_CYC + 1);
    localparam logic [MW-1:0] MUTEV = MW'(MUTE_CYC);

    logic [MW-1:0] mute_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault    <= 1'b0;
            mute_cnt <= '0;
        end else if (desat) begin
            fault    <= 1'b1;
            mute_cnt <= MUTEV;
        end else begin
            if (mute_cnt != '0)
                mute_cnt <= mute_cnt - 1'b1;
            if (fault && arm_full && rise)
                fault <= 1'b0;
        end
    end

    assign mute_done = (mute_cnt == '0);

    // R2 R8
    desat_latch_chk: assert property (@(posedge clk) disable iff (rst)
        desat |=> fault && mute_cnt == MUTEV);
    // R3
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault && !(arm_full && rise) |=> fault);
    // R4
    mute_block_chk: assert property (@(posedge clk) disable iff (rst)
        fault && mute_cnt != '0 |=> fault);
    // R5
    clear_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        fault && !desat && arm_full && rise |=> !fault);
endmodule

// File: rtl/gdrv_fault_ctrl.sv
module gdrv_fault_ctrl
    import gdrv_pkg::*;
#(
    parameter int MUTE_CYC = 64,
    parameter int FILT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic desat_pulse,
    input  logic rsten_in,
    input  logic pwm_cmd,
    output logic flt_pull_low,
    output logic gate_drive,
    output logic strong_pd
);
    logic lvl, rise, dis_full, arm_full, fault, mute_done;
    gdrv_state_t st;
    gdrv_out_t   o;

    gdrv_sync u_sync (
        .clk(clk), .rst(rst), .async_in(rsten_in), .lvl(lvl), .rise(rise)
    );

    gdrv_low_filter #(.FILT_CYC(FILT_CYC), .RST_FULL(1'b1)) u_en_filt (
        .clk(clk), .rst(rst), .lvl(lvl), .count_en(1'b1), .clr(1'b0),
        .full(dis_full)
    );

    gdrv_low_filter #(.FILT_CYC(FILT_CYC), .RST_FULL(1'b0)) u_arm_filt (
        .clk(clk), .rst(rst), .lvl(lvl), .count_en(fault && mute_done),
        .clr(desat_pulse || !fault), .full(arm_full)
    );

    gdrv_fault_latch #(.MUTE_CYC(MUTE_CYC)) u_latch (
        .clk(clk), .rst(rst), .desat(desat_pulse), .arm_full(arm_full),
        .rise(rise), .fault(fault), .mute_done(mute_done)
    );

    assign st.fault    = fault;
    assign st.disabled = dis_full;
    assign o           = drive_outputs(st, pwm_cmd);

    assign flt_pull_low = o.flt_pull_low;
    assign gate_drive   = o.gate_drive;
    assign strong_pd    = o.strong_pd;

    // R7
    fault_gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        flt_pull_low |-> !gate_drive && strong_pd);
    // R9
    gate_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_drive && strong_pd));
endmodule

// File: tb/test_gdrv_fault_ctrl.sv
module test_gdrv_fault_ctrl;
    localparam int MUTE = 12;
    localparam int FILT = 4;

    logic clk = 1'b0, rst = 1'b1, desat = 1'b0, rsten = 1'b0, pwm = 1'b0;
    logic flt, gate, pd;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gdrv_fault_ctrl #(.MUTE_CYC(MUTE), .FILT_CYC(FILT)) i_gdrv_fault_ctrl (
        .clk(clk), .rst(rst), .desat_pulse(desat), .rsten_in(rsten),
        .pwm_cmd(pwm), .flt_pull_low(flt), .gate_drive(gate), .strong_pd(pd)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // fire one desat pulse; returns at the negedge after the sampling edge
    task automatic fire_desat();
        desat = 1'b1;
        cyc(1);
        desat = 1'b0;
    endtask

    // clean clear once mute has expired
    task automatic clean_clear();
        rsten = 1'b0;
        cyc(FILT + 3);
        chk("R5 flag held while line low", flt, 1'b1);
        rsten = 1'b1;
        cyc(2);
        chk("R5 not yet cleared before edge", flt, 1'b1);
        cyc(1);
        chk("R5 cleared on rising edge", flt, 1'b0);
        cyc(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        pwm = 1'b1;
        cyc(1);
        chk("R1 flag released", flt, 1'b0);
        chk("R1 gate off", gate, 1'b0);
        chk("R1 pulldown on", pd, 1'b1);

        rsten = 1'b1;
        cyc(4);
        for (int p = 0; p < 2; p++) begin
            pwm = p[0];
            #1;
            chk("R9 gate follows pwm", gate, p[0]);
            chk("R9 pulldown off", pd, 1'b0);
            cyc(1);
        end

        // R6 sweep of low pulse lengths
        for (int d = 1; d <= FILT + 2; d++) begin
            rsten = 1'b0;
            for (int n = 1; n <= d + 4; n++) begin
                cyc(1);
                if (n == d) rsten = 1'b1;
                chk("R6 enable filter", pd,
                    (n >= 3 && n <= d + 2 && (n - 2) >= FILT) ? 1'b1 : 1'b0);
            end
            cyc(2);
        end

        // R2 / R7
        pwm = 1'b1;
        fire_desat();
        chk("R2 fault latched", flt, 1'b1);
        chk("R7 gate off on fault", gate, 1'b0);
        chk("R7 pulldown on fault", pd, 1'b1);

        // R3: short lows never clear, even well after mute
        for (int k = 0; k < 8; k++) begin
            rsten = 1'b0;
            cyc(FILT - 1);
            rsten = 1'b1;
            cyc(4);
            chk("R3 fault persists", flt, 1'b1);
            chk("R7 gate off while faulted", gate, 1'b0);
        end
        cyc(MUTE);
        chk("R3 no self clear", flt, 1'b1);
        clean_clear();
        chk("R9 gate back after clear", gate, 1'b1);

        // R4 / R5 sweep across the end of the mute window
        for (int w = MUTE - 3; w <= MUTE + 1; w++) begin
            for (int d = FILT - 1; d <= FILT + 1; d++) begin
                int lo, hi, counted;
                fire_desat();
                cyc(w);
                rsten = 1'b0;
                cyc(d);
                rsten = 1'b1;
                cyc(4);
                lo = (w + 3 > MUTE + 1) ? w + 3 : MUTE + 1;
                hi = w + 2 + d;
                counted = (hi >= lo) ? hi - lo + 1 : 0;
                chk("R4 post-mute low counting", flt, (counted >= FILT) ? 1'b0 : 1'b1);
                if (flt) clean_clear();
                else cyc(2);
            end
        end

        // R8: second desat restarts the mute window
        fire_desat();
        cyc(MUTE - 2);
        fire_desat();
        rsten = 1'b0;
        cyc(FILT + 1);
        rsten = 1'b1;
        cyc(4);
        chk("R8 mute restarted, no clear", flt, 1'b1);
        cyc(MUTE);
        clean_clear();

        // R6 line low disables driver after filter even with no fault
        rsten = 1'b0;
        cyc(FILT + 1);
        chk("R6 still enabled before filter", pd, 1'b0);
        cyc(1);
        chk("R6 disabled after filter", pd, 1'b1);
        chk("R6 gate off when disabled", gate, 1'b0);

        finished = 1;
        summary();
    end
endmodule